// File: doc/BRIEF.md
# Capacity LED Bar Driver

This block turns a battery gauge's compensated remaining-charge count into a five-segment LED bar. The number of lit segments follows the remaining count as a share of the learned full-capacity value, each segment standing for one fifth of that value. The segments are split into two banks that take turns on a shared common enable. Each bank is lit for a short slot in every multiplexing period, which keeps the average LED current low.

On top of the bar, the block shows two alarm levels. The early end-of-discharge flag makes the first segment blink. The final end-of-discharge flag blanks the whole display. A two-bit mode input selects how the display is enabled:
- never shown;
- shown only while charge is flowing;
- shown for a fixed time after a button press.

All timing is counted in ticks of an external timebase strobe, 1 kHz by default.

Top module: `capacity_bar_driver`

## Requirements
- R1: The number of lit segments is the smallest whole number n with n*fullRef >= 5*availCount, limited to at most 5. A zero count lights nothing. A zero reference with a nonzero count lights all five segments.
- R2: Lit segments form a bar that starts at segment 1 (segEn bit 0) and fills upward toward segment 5 (bit 4).
- R3: Bits 0, 2 and 4 form bank A and bits 1 and 3 form bank B. No cycle shows both banks at once. segEn is zero whenever comEn is low.
- R4: Each multiplex period is 10 ticks long, giving 100 Hz at a 1 kHz tick. Bank A is driven in ticks 0..2 of the period and bank B in ticks 5..7, so comEn is high for exactly 6 of any 10 consecutive ticks while the display is shown.
- R5: While edvWarn is high, segment 1 ignores the count and follows a 4 Hz square wave, 125 ticks lit and 125 ticks dark. It keeps its bank-A slot timing.
- R6: While edvEmpty is high, segEn and comEn are all zero, whatever the mode.
- R7: modeSel 2'b10 or 2'b11 disables the display, so comEn stays low.
- R8: modeSel 2'b01 shows the display only while chargeActive is high, unless a button window is still running.
- R9: Entering modeSel 2'b00 starts a 4000-tick window (4 s) during which the display is shown. It goes dark when the window ends, even if the input stays at 2'b00.
- R10: Leaving 2'b00 and entering it again while a window runs reloads the window to its full length.
- R11: During reset, segEn and comEn are zero. Outputs are registered and reflect inputs one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase strobe, one clock wide per tick |
| availCount | input | CNT_W | Compensated remaining-charge count |
| fullRef | input | CNT_W | Learned full-capacity reference |
| chargeActive | input | 1 | Charge current currently flowing |
| edvWarn | input | 1 | Early end-of-discharge flag |
| edvEmpty | input | 1 | Final end-of-discharge flag |
| modeSel | input | 2 | 00 button window, 01 while charging, 1x disabled |
| segEn | output | NUM_SEG | Segment enables, bit 0 is segment 1 |
| comEn | output | 1 | Common enable for the active bank |

## Verification
The bar is driven with counts that sit exactly on a fifth boundary and one count above it, with a count above the reference, with zero counts, and with a zero reference. These cases separate a ceiling from a floor or a rounding rule, and they show whether the clamp works. Each 10-tick window is measured as the union of lit segments plus the number of cycles with comEn, bank-A and bank-B activity. This tells wrong slot lengths or bank assignments apart from wrong fill levels. The blink is measured by counting lit cycles over four blink periods, both with a full bar and with an empty count. The button window is sampled just before and just after its nominal end, both for a single press and for a press repeated halfway through.

// File: rtl/capacity_bar_pkg.sv
package capacity_bar_pkg;

  // Display enable selection carried on the two-bit mode input.
  typedef enum logic [1:0] {
    MODE_BUTTON  = 2'b00,
    MODE_CHARGE  = 2'b01,
    MODE_OFF     = 2'b10,
    MODE_OFF_ALT = 2'b11
  } dispMode_t;

  // Strobes handed from the timing control to the segment datapath.
  typedef struct packed {
    logic bankA;     // odd-numbered segments may be driven now
    logic bankB;     // even-numbered segments may be driven now
    logic blinkLit;  // lit half of the low-battery blink
    logic show;      // display enabled by mode and alarm state
  } barStrobe_t;

endpackage

// File: rtl/capacity_bar_ctrl.sv
module capacity_bar_ctrl
  import capacity_bar_pkg::*;
#(
  parameter int TICKS_PER_SEC = 1000,
  parameter int MUX_HZ        = 100,
  parameter int DUTY_PCT      = 30,
  parameter int BLINK_HZ      = 4,
  parameter int WINDOW_SEC    = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic [1:0] modeSel,
  input  logic       chargeActive,
  input  logic       edvEmpty,
  output barStrobe_t strobe
);

  localparam int MUX_TICKS  = TICKS_PER_SEC / MUX_HZ;
  localparam int SLOT_TICKS = MUX_TICKS / 2;
  localparam int ON_TICKS   = (MUX_TICKS * DUTY_PCT) / 100;
  localparam int BLINK_HALF = TICKS_PER_SEC / (2 * BLINK_HZ);
  localparam int WIN_TICKS  = WINDOW_SEC * TICKS_PER_SEC;
  localparam int PH_W       = $clog2(MUX_TICKS);
  localparam int BL_W       = $clog2(BLINK_HALF);
  localparam int WIN_W      = $clog2(WIN_TICKS + 1);

  localparam logic [PH_W-1:0]  PH_LAST   = PH_W'(MUX_TICKS - 1);
  localparam logic [PH_W-1:0]  PH_A_END  = PH_W'(ON_TICKS);
  localparam logic [PH_W-1:0]  PH_B_BEG  = PH_W'(SLOT_TICKS);
  localparam logic [PH_W-1:0]  PH_B_END  = PH_W'(SLOT_TICKS + ON_TICKS);
  localparam logic [BL_W-1:0]  BL_LAST   = BL_W'(BLINK_HALF - 1);
  localparam logic [WIN_W-1:0] WIN_LOAD  = WIN_W'(WIN_TICKS);

  logic [PH_W-1:0]  muxPhase;
  logic [BL_W-1:0]  blinkCnt;
  logic             blinkDark;
  logic [WIN_W-1:0] winLeft;
  logic             btnSeen;

  logic modeOff, modeBtn, modeChg, btnStart, winRunning;

  assign modeOff    = modeSel[1];
  assign modeBtn    = (modeSel == MODE_BUTTON);
  assign modeChg    = (modeSel == MODE_CHARGE);
  assign btnStart   = modeBtn && !btnSeen;
  assign winRunning = (winLeft != '0);

  // Multiplex period phase.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      muxPhase <= '0;
    end else if (tick) begin
      muxPhase <= (muxPhase == PH_LAST) ? '0 : muxPhase + 1'b1;
    end
  end

  // Low-battery blink half-period counter.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      blinkCnt  <= '0;
      blinkDark <= 1'b0;
    end else if (tick) begin
      if (blinkCnt == BL_LAST) begin
        blinkCnt  <= '0;
        blinkDark <= !blinkDark;
      end else begin
        blinkCnt <= blinkCnt + 1'b1;
      end
    end
  end

  // Button window: armed on entry into the button code, reloaded on re-entry.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      btnSeen <= 1'b0;
      winLeft <= '0;
    end else begin
      btnSeen <= modeBtn;
      if (modeOff) begin
        winLeft <= '0;
      end else if (btnStart) begin
        winLeft <= WIN_LOAD;
      end else if (tick && winRunning) begin
        winLeft <= winLeft - 1'b1;
      end
    end
  end

  always_comb begin
    strobe.bankA    = (muxPhase < PH_A_END);
    strobe.bankB    = (muxPhase >= PH_B_BEG) && (muxPhase < PH_B_END);
    strobe.blinkLit = !blinkDark;
    strobe.show     = !modeOff && !edvEmpty &&
                      ((modeChg && chargeActive) || winRunning);
  end

endmodule

// File: rtl/capacity_bar_dp.sv
module capacity_bar_dp
  import capacity_bar_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_SEG = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CNT_W-1:0]   availCount,
  input  logic [CNT_W-1:0]   fullRef,
  input  logic               edvWarn,
  input  barStrobe_t         strobe,
  output logic [NUM_SEG-1:0] segEn,
  output logic               comEn
);

  localparam int PROD_W = CNT_W + $clog2(NUM_SEG + 1);

  logic [PROD_W-1:0]  scaledAvail;
  logic [NUM_SEG-1:0] fillBar;
  logic [NUM_SEG-1:0] laneOn;
  logic [NUM_SEG-1:0] segNext;
  logic               comNext;

  assign scaledAvail = PROD_W'(availCount) * PROD_W'(NUM_SEG);

  // Segment k+1 is lit when NUM_SEG*avail exceeds k*ref: a ceiling without a divider.
  for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
    if (k == 0) begin : g_first
      assign fillBar[k] = edvWarn ? strobe.blinkLit : (availCount != '0);
    end else begin : g_upper
      logic [PROD_W-1:0] refStep;
      assign refStep    = PROD_W'(fullRef) * PROD_W'(k);
      assign fillBar[k] = (scaledAvail > refStep);
    end
    if ((k % 2) == 0) begin : g_bankA
      assign laneOn[k] = strobe.bankA;
    end else begin : g_bankB
      assign laneOn[k] = strobe.bankB;
    end
  end

  assign segNext = strobe.show ? (fillBar & laneOn) : '0;
  assign comNext = strobe.show && (strobe.bankA || strobe.bankB);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      segEn <= '0;
      comEn <= 1'b0;
    end else begin
      segEn <= segNext;
      comEn <= comNext;
    end
  end

endmodule

// File: rtl/capacity_bar_driver.sv
module capacity_bar_driver
  import capacity_bar_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int NUM_SEG       = 5,
  parameter int TICKS_PER_SEC = 1000,
  parameter int MUX_HZ        = 100,
  parameter int DUTY_PCT      = 30,
  parameter int BLINK_HZ      = 4,
  parameter int WINDOW_SEC    = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic [CNT_W-1:0]   availCount,
  input  logic [CNT_W-1:0]   fullRef,
  input  logic               chargeActive,
  input  logic               edvWarn,
  input  logic               edvEmpty,
  input  logic [1:0]         modeSel,
  output logic [NUM_SEG-1:0] segEn,
  output logic               comEn
);

  barStrobe_t strobe;

  capacity_bar_ctrl #(
    .TICKS_PER_SEC (TICKS_PER_SEC),
    .MUX_HZ        (MUX_HZ),
    .DUTY_PCT      (DUTY_PCT),
    .BLINK_HZ      (BLINK_HZ),
    .WINDOW_SEC    (WINDOW_SEC)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .tick         (tick),
    .modeSel      (modeSel),
    .chargeActive (chargeActive),
    .edvEmpty     (edvEmpty),
    .strobe       (strobe)
  );

  capacity_bar_dp #(
    .CNT_W   (CNT_W),
    .NUM_SEG (NUM_SEG)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .availCount (availCount),
    .fullRef    (fullRef),
    .edvWarn    (edvWarn),
    .strobe     (strobe),
    .segEn      (segEn),
    .comEn      (comEn)
  );

endmodule

// File: rtl/capacity_bar_checker.sv
module capacity_bar_checker #(
  parameter int CNT_W   = 16,
  parameter int NUM_SEG = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic [CNT_W-1:0]   availCount,
  input logic [CNT_W-1:0]   fullRef,
  input logic               edvEmpty,
  input logic [1:0]         modeSel,
  input logic [NUM_SEG-1:0] segEn,
  input logic               comEn
);

  logic hitA, hitB;
  logic [CNT_W+3:0] availScaled, refTop;

  always_comb begin
    hitA = 1'b0;
    hitB = 1'b0;
    for (int i = 0; i < NUM_SEG; i++) begin
      if ((i % 2) == 0) hitA = hitA | segEn[i];
      else              hitB = hitB | segEn[i];
    end
  end

  assign availScaled = (CNT_W+4)'(availCount) * (CNT_W+4)'(NUM_SEG);
  assign refTop      = (CNT_W+4)'(fullRef) * (CNT_W+4)'(NUM_SEG - 1);

  // R3: the two banks never share a cycle
  assert_bank_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(hitA && hitB));

  // R3: no segment without the common enable
  assert_seg_needs_com_R3: assert property (@(posedge clk) disable iff (!rstN)
    (segEn != '0) |-> comEn);

  // R6: final alarm blanks everything one clock later
  assert_empty_blank_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(edvEmpty) |-> (segEn == '0 && !comEn));

  // R7: disabled mode keeps the common enable off
  assert_off_mode_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(modeSel[1]) |-> !comEn);

  // R1: top segment only when the count exceeds four fifths of the reference
  assert_top_segment_R1: assert property (@(posedge clk) disable iff (!rstN)
    segEn[NUM_SEG-1] |-> $past(availScaled > refTop));

endmodule

bind capacity_bar_driver capacity_bar_checker #(
  .CNT_W   (CNT_W),
  .NUM_SEG (NUM_SEG)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .availCount (availCount),
  .fullRef    (fullRef),
  .edvEmpty   (edvEmpty),
  .modeSel    (modeSel),
  .segEn      (segEn),
  .comEn      (comEn)
);

// File: tb/capacity_bar_driver_bench.sv
module capacity_bar_driver_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b1;
  logic [15:0] availCount = '0;
  logic [15:0] fullRef = 16'd1000;
  logic        chargeActive = 1'b0;
  logic        edvWarn = 1'b0;
  logic        edvEmpty = 1'b0;
  logic [1:0]  modeSel = 2'b10;
  logic [4:0]  segEn;
  logic        comEn;

  int checkCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  // scoreboard queues
  logic [4:0] qUnion[$];
  int         qOn[$];
  int         qA[$];
  int         qB[$];
  string      qTag[$];

  event measGo;
  event measDone;

  always #10 clk = ~clk;

  capacity_bar_driver u_capacity_bar_driver (
    .clk          (clk),
    .rstN         (rstN),
    .tick         (tick),
    .availCount   (availCount),
    .fullRef      (fullRef),
    .chargeActive (chargeActive),
    .edvWarn      (edvWarn),
    .edvEmpty     (edvEmpty),
    .modeSel      (modeSel),
    .segEn        (segEn),
    .comEn        (comEn)
  );

  task automatic report(input bit ok, input string msg);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s", msg);
    end
  endtask

  // Monitor: measures one 10-tick period and compares with the queued item.
  initial begin
    forever begin
      logic [4:0] uni;
      int onC, aC, bC, mix;
      @(measGo);
      uni = '0; onC = 0; aC = 0; bC = 0; mix = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        uni |= segEn;
        if (comEn) onC++;
        if (segEn[0]) aC++;
        if (segEn[1]) bC++;
        if ((|(segEn & 5'b10101)) && (|(segEn & 5'b01010))) mix++;
        if (segEn != '0 && !comEn) mix++;
      end
      begin
        logic [4:0] eU;
        int eOn, eA, eB;
        string tg;
        eU = qUnion.pop_front(); eOn = qOn.pop_front();
        eA = qA.pop_front(); eB = qB.pop_front(); tg = qTag.pop_front();
        report(uni == eU && onC == eOn && aC == eA && bC == eB,
          $sformatf("%s union=%b on=%0d a=%0d b=%0d expected union=%b on=%0d a=%0d b=%0d",
                    tg, uni, onC, aC, bC, eU, eOn, eA, eB));
        report(mix == 0, $sformatf("R3 bank overlap count=%0d expected 0 (%s)", mix, tg));
      end
      -> measDone;
    end
  end

  // Driver: push the expectation, let inputs settle, run one measurement.
  task automatic expectWindow(input string tag, input logic [4:0] u,
                              input int on, input int a, input int b);
    qUnion.push_back(u); qOn.push_back(on); qA.push_back(a); qB.push_back(b);
    qTag.push_back(tag);
    repeat (20) @(negedge clk);
    -> measGo;
    @(measDone);
  endtask

  task automatic countCom(output int n);
    n = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (comEn) n++;
    end
  endtask

  initial begin
    int n, c0, c2;
    // R11: reset state
    repeat (5) @(negedge clk);
    report(segEn == '0 && !comEn,
           $sformatf("R11 during reset seg=%b com=%b expected 00000/0", segEn, comEn));
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    report(segEn == '0 && !comEn,
           $sformatf("R11 after reset in off mode seg=%b com=%b expected 00000/0", segEn, comEn));

    // Show while charging, vary the fill level (R1, R2, R4)
    modeSel = 2'b01; chargeActive = 1'b1;
    availCount = 16'd1000;
    expectWindow("R4 full bar", 5'b11111, 6, 3, 3);
    availCount = 16'd1;
    expectWindow("R1 one count lights one", 5'b00001, 6, 3, 0);
    availCount = 16'd200;
    expectWindow("R1 exact fifth", 5'b00001, 6, 3, 0);
    availCount = 16'd201;
    expectWindow("R1 just above a fifth", 5'b00011, 6, 3, 3);
    availCount = 16'd600;
    expectWindow("R2 three fifths bar", 5'b00111, 6, 3, 3);
    availCount = 16'd0;
    expectWindow("R1 zero count", 5'b00000, 6, 0, 0);
    availCount = 16'd1500;
    expectWindow("R1 clamp above reference", 5'b11111, 6, 3, 3);
    fullRef = 16'd0; availCount = 16'd5;
    expectWindow("R1 zero reference", 5'b11111, 6, 3, 3);
    availCount = 16'd0;
    expectWindow("R1 zero reference zero count", 5'b00000, 6, 0, 0);
    fullRef = 16'd1000; availCount = 16'd1000;

    // Mode and alarm gating
    chargeActive = 1'b0;
    expectWindow("R8 no charge", 5'b00000, 0, 0, 0);
    chargeActive = 1'b1; modeSel = 2'b10;
    expectWindow("R7 disabled", 5'b00000, 0, 0, 0);
    modeSel = 2'b11;
    expectWindow("R7 disabled alt code", 5'b00000, 0, 0, 0);
    modeSel = 2'b01; edvEmpty = 1'b1; edvWarn = 1'b1;
    expectWindow("R6 empty blanks", 5'b00000, 0, 0, 0);
    edvEmpty = 1'b0;

    // R5: blink with a full bar, then with a zero count
    repeat (20) @(negedge clk);
    c0 = 0; c2 = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (segEn[0]) c0++;
      if (segEn[2]) c2++;
    end
    report(c0 >= 140 && c0 <= 160, $sformatf("R5 blink seg1 lit=%0d expected 140..160", c0));
    report(c2 == 300, $sformatf("R5 seg3 steady lit=%0d expected 300", c2));
    availCount = 16'd0;
    repeat (20) @(negedge clk);
    c0 = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (segEn[0]) c0++;
    end
    report(c0 >= 140 && c0 <= 160, $sformatf("R5 blink at zero count lit=%0d expected 140..160", c0));
    edvWarn = 1'b0; availCount = 16'd1000;

    // R9: button window
    chargeActive = 1'b0;
    repeat (20) @(negedge clk);
    modeSel = 2'b00;
    repeat (100) @(negedge clk);
    countCom(n);
    report(n == 6, $sformatf("R9 window start on=%0d expected 6", n));
    repeat (3780) @(negedge clk);
    countCom(n);
    report(n == 6, $sformatf("R9 window near end on=%0d expected 6", n));
    repeat (200) @(negedge clk);
    countCom(n);
    report(n == 0, $sformatf("R9 window expired on=%0d expected 0", n));

    // R10: repeated press reloads the window
    modeSel = 2'b01;
    repeat (20) @(negedge clk);
    modeSel = 2'b00;
    repeat (2000) @(negedge clk);
    modeSel = 2'b01;
    repeat (5) @(negedge clk);
    modeSel = 2'b00;
    repeat (3890) @(negedge clk);
    countCom(n);
    report(n == 6, $sformatf("R10 restarted window still on=%0d expected 6", n));
    repeat (200) @(negedge clk);
    countCom(n);
    report(n == 0, $sformatf("R10 restarted window expired on=%0d expected 0", n));

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1'b1;
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

endmodule